// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and one asynchronous static RAM of 64K words of 4 bits. The host hands it one word-wide request at a time (address, write flag, write data) through a valid/ready handshake. The block turns each request into the pin sequence the RAM needs: active-low chip select, write strobe and output enable, plus a 4-bit data bus split into a driven value, a driver enable and a sampled input. The host gets read data back with a single-cycle valid pulse.

Every RAM access runs through the same four phases. Idle is first. Setup follows, where the address and chip select are applied with both strobes released. Then comes an active phase of a counted length, where either the write strobe or the output enable is held low. Recovery comes last, where every strobe is released for one bus turnaround cycle. The lengths are not written in as fixed numbers. They are derived from nanosecond parameters and the clock period by ceiling division. Output enable stays high for the whole of every write, so the write strobe never has to be stretched to cover the RAM turning off its own output drivers.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the sequencer is idle, and chip select is never low while `req_ready` is 1.
- R3: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for its active phase. Output enable is never low unless chip select is low and the write strobe is high.
- R4: Read data is taken from `mem_dq_i` on the edge that ends the active phase. It is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle, 2+RD cycles after the accepting edge. Writes produce no `rsp_valid`.
- R5: A write holds `mem_cs_n`=0 and `mem_we_n`=0 with `mem_oe_n`=1. The write data and address are on `mem_dq_o` and `mem_addr` for the whole strobe.
- R6: `mem_dq_oe` is 1 only while chip select and the write strobe are low and output enable is high. The block therefore never drives the bus while the RAM may be driving it.
- R7: `mem_addr` holds steady on every cycle where chip select stays low. Each access begins with one setup cycle in which chip select is low, both strobes are high and `mem_dq_oe` is 0.
- R8: Every access ends with one recovery cycle in which chip select and both strobes are high. `req_ready` returns 3+N cycles after the accepting edge, where N is RD for a read and WR for a write.
- R9: WR = max(ceil(write pulse / period), ceil(data setup / period)). RD = max(ceil(access / period), ceil(output-enable access / period), ceil(cycle / period) - 1). With a 5 ns period and the defaults (9, 6, 12, 6, 12 ns) this gives WR=2 and RD=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_o | output | DATA_W | Value driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_i | input | DATA_W | Value sampled from the RAM data bus |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
Two events can land on the same edge: a read's data capture and the release of output enable that ends the read. The bench's RAM model returns the true word only once output enable has been low for the full RD count. An early sample therefore gets a corrupted word, and a late one falls after the bus has stopped being driven. The second overlap is a new request arriving right after a recovery, against the last cycles of the previous write. Back-to-back write/read pairs to the same address are used to check that the written word is committed at the rise of the strobe, before the next read's setup.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | run;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = run && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_wr,
  input  logic       cnt_last,
  output seq_state_e state,
  output logic       cnt_load,
  output logic       cnt_run,
  output logic       capture,
  output logic       cs_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  seq_state_e st_q;
  seq_state_e st_d;
  logic       cs_n_d;
  logic       we_n_d;
  logic       oe_n_d;
  logic       dq_oe_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start)    st_d = ST_SETUP;
      ST_SETUP:                 st_d = ST_ACTIVE;
      ST_ACTIVE:  if (cnt_last) st_d = ST_RECOVER;
      ST_RECOVER:               st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cs_n_d  = !((st_d == ST_SETUP) || (st_d == ST_ACTIVE));
    we_n_d  = !((st_d == ST_ACTIVE) && op_wr);
    oe_n_d  = !((st_d == ST_ACTIVE) && !op_wr);
    dq_oe_d = (st_d == ST_ACTIVE) && op_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs_n  <= cs_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= dq_oe_d;
    end
  end

  assign state    = st_q;
  assign cnt_load = (st_q == ST_SETUP);
  assign cnt_run  = (st_q == ST_ACTIVE);
  assign capture  = (st_q == ST_ACTIVE) && cnt_last && !op_wr;

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic              op_wr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (take) begin
      op_wr <= in_we;
      addr  <= in_addr;
      wdata <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 5,
  parameter int T_WP_NS  = 9,
  parameter int T_DW_NS  = 6,
  parameter int T_AA_NS  = 12,
  parameter int T_OE_NS  = 6,
  parameter int T_RC_NS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int WR_CYC = int'(umax(umax(ns_to_cyc(T_WP_NS, CLK_NS),
                                         ns_to_cyc(T_DW_NS, CLK_NS)), 1));
  localparam int RC_ACT = int'(umax(ns_to_cyc(T_RC_NS, CLK_NS), 2)) - 1;
  localparam int RD_CYC = int'(umax(umax(ns_to_cyc(T_AA_NS, CLK_NS),
                                         ns_to_cyc(T_OE_NS, CLK_NS)),
                                    umax(RC_ACT, 1)));
  localparam int CNT_W  = $clog2(int'(umax(WR_CYC, RD_CYC)) + 1);

  seq_state_e       state;
  logic             take;
  logic             op_wr;
  logic             cnt_load;
  logic             cnt_run;
  logic             cnt_last;
  logic             capture;
  logic [CNT_W-1:0] cnt_init;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign cnt_init  = op_wr ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);

  sram_ctl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .in_we    (req_we),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .capture  (capture),
    .bus_in   (mem_dq_i),
    .op_wr    (op_wr),
    .addr     (mem_addr),
    .wdata    (mem_dq_o),
    .rdata    (rsp_rdata),
    .rvalid   (rsp_valid)
  );

  sram_ctl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_init),
    .run      (cnt_run),
    .last     (cnt_last)
  );

  sram_ctl_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (take),
    .op_wr    (op_wr),
    .cnt_last (cnt_last),
    .state    (state),
    .cnt_load (cnt_load),
    .cnt_run  (cnt_run),
    .capture  (capture),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int WR_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);

  logic [7:0] we_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_len_q <= '0;
    end else if (mem_we_n) begin
      we_len_q <= '0;
    end else if (we_len_q != 8'hff) begin
      we_len_q <= we_len_q + 1'b1;
    end
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  p_read_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_we_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_len_q == 8'(WR_CYC)));

  p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && !mem_cs_n));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_setup_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_n) || $fell(mem_oe_n)) |-> $past(!mem_cs_n && !mem_dq_oe));

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |=> mem_cs_n);

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .WR_CYC (WR_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

  function automatic int cdiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PER  = 5;
  localparam int WR_N = imax(cdiv(9, PER), cdiv(6, PER));
  localparam int RD_N = imax(imax(cdiv(12, PER), cdiv(6, PER)), cdiv(12, PER) - 1);

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_we;
  logic [15:0] req_addr;
  logic [3:0]  req_wdata;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [15:0] mem_addr;
  logic [3:0]  mem_dq_o;
  logic        mem_dq_oe;
  logic [3:0]  mem_dq_i;
  logic        mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [3:0] bmem [int];
  logic [3:0] emem [int];

  sram_ctl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_i  (mem_dq_i),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [3:0] bget(input int a);
    return bmem.exists(a) ? bmem[a] : 4'h0;
  endfunction
  function automatic logic [3:0] eget(input int a);
    return emem.exists(a) ? emem[a] : 4'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // RAM model: true data only after output enable has been low RD_N cycles
  int         oe_cyc = 0;
  int         we_cyc = 0;
  int         d_cyc  = 0;
  bit         oe_in_wr = 0;
  logic [3:0] wd;
  int         wa;
  bit         p_cs_low = 0;
  bit         p_we_high = 1;
  bit         p_dq_oe = 0;
  logic [15:0] p_addr = '0;

  always @(posedge clk) begin
    int n;
    if (rst_n) begin
      n = (!mem_cs_n && !mem_oe_n && mem_we_n) ? oe_cyc + 1 : 0;
      oe_cyc = n;
      mem_dq_i <= (n != 0 && n + 1 >= RD_N) ? bget(int'(mem_addr)) : ~bget(int'(mem_addr));
      if (mem_dq_oe && (!mem_oe_n || mem_we_n || mem_cs_n))
        chk(0, "R6", "bus driven outside write strobe", 1, 0);
      if (!mem_cs_n && p_cs_low && (mem_addr != p_addr))
        chk(0, "R7", "address moved under chip select", int'(mem_addr), int'(p_addr));
      if (!mem_cs_n && !mem_we_n) begin
        if (we_cyc == 0)
          chk(p_cs_low && p_we_high && !p_dq_oe, "R7", "setup before strobe", 0, 1);
        we_cyc++;
        if (mem_dq_oe) d_cyc++;
        if (!mem_oe_n) oe_in_wr = 1;
        wd = mem_dq_o;
        wa = int'(mem_addr);
      end else if (we_cyc > 0) begin
        chk(we_cyc == WR_N, "R9", "write strobe length", we_cyc, WR_N);
        chk(d_cyc == we_cyc && !oe_in_wr, "R5", "data driven with OE high", d_cyc, we_cyc);
        bmem[wa] = wd;
        we_cyc = 0;
        d_cyc = 0;
        oe_in_wr = 0;
      end
      p_cs_low  = !mem_cs_n;
      p_we_high = mem_we_n;
      p_dq_oe   = mem_dq_oe;
      p_addr    = mem_addr;
    end
  end

  task automatic do_op(input logic wr, input logic [15:0] a, input logic [3:0] d);
    int n;
    int rsp_n;
    int rsp_cnt;
    int lim;
    logic [3:0] got;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_we    = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_we    = 1'($urandom);
    req_addr  = 16'($urandom);
    req_wdata = 4'($urandom);
    n = 1;
    rsp_n = 0;
    rsp_cnt = 0;
    got = '0;
    lim = wr ? WR_N : RD_N;
    chk(!req_ready, "R2", "ready while busy", int'(req_ready), 0);
    chk(!mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R7", "setup pins",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
    while (!req_ready && n < 60) begin
      if (n == 2) begin
        if (wr)
          chk(!mem_cs_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == d && mem_addr == a,
              "R5", "write active pins", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
        else
          chk(!mem_cs_n && mem_we_n && !mem_oe_n && !mem_dq_oe && mem_addr == a,
              "R3", "read active pins", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0100);
      end
      if (n == 2 + lim)
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R8", "recovery pins",
            {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
      if (rsp_valid) begin
        rsp_cnt++;
        rsp_n = n;
        got = rsp_rdata;
      end
      @(negedge clk);
      n++;
    end
    chk(n == 3 + lim, "R8", "ready latency", n, 3 + lim);
    if (wr) begin
      chk(rsp_cnt == 0, "R4", "no response on write", rsp_cnt, 0);
      emem[int'(a)] = d;
    end else begin
      chk(rsp_cnt == 1 && rsp_n == 2 + RD_N, "R4", "response timing", rsp_n, 2 + RD_N);
      chk(got == eget(int'(a)), "R4", "read data", int'(got), int'(eget(int'(a))));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: cycles=%0d expected below %0d", 150000, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    mem_dq_i  = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1", "reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "reset pins",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

    // directed corners: address extremes, overwrite, back-to-back write/read
    do_op(1'b1, 16'h0000, 4'h5);
    do_op(1'b1, 16'hffff, 4'ha);
    do_op(1'b0, 16'h0000, 4'h0);
    do_op(1'b0, 16'hffff, 4'h0);
    do_op(1'b1, 16'hffff, 4'h3);
    do_op(1'b0, 16'hffff, 4'h0);
    do_op(1'b0, 16'h1234, 4'h0);
    do_op(1'b1, 16'h8001, 4'hf);
    do_op(1'b0, 16'h8001, 4'h0);

    for (int i = 0; i < 150; i++) begin
      logic [15:0] a;
      a = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom % 16);
      do_op(1'($urandom), a, 4'($urandom));
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule